// File: doc/BRIEF.md
# Parallel Unit Sync Bus Loop

This block keeps one power-conversion unit aligned with its peers in a parallel group. Every unit shares a single sync line with the others. Each unit drives onto that line a square wave taken from its own reference counter. The line carries the combined value of all the units. When the combined line shows an active edge, each unit receives a one-cycle request to clear its reference counter. All reference counters then restart together.

The generated sine is stepped through a sample index. The index advances once per PWM carrier period. When the index reaches the middle of the sine cycle, the block samples the reference counter and compares it with half the reference period. A fast proportional-integral regulator turns that error into a correction of the carrier period. A sine that runs late gets shorter carrier periods, and a sine that runs early gets longer ones. The result is clamped between a lower and an upper limit, and the integrator saturates so that it cannot wind up.

The regulator is a four-state machine. It rests in `PI_IDLE` and leaves it only on a midpoint event (IDLE→ERROR). In `PI_ERROR` it latches the error (ERROR→INTEG). In `PI_INTEG` it updates the saturating integrator (INTEG→APPLY). In `PI_APPLY` it stores the new correction (APPLY→IDLE).

Top module: `sbl_top`

## Requirements
- R1: `sync_out` is a registered copy of the comparison `ref_cnt < floor(ref_prd/2)`. It is 1 in the cycle after an edge that sampled `ref_cnt` below half the period, and 0 otherwise.
- R2: `sync_in` passes through a two-flop synchronizer. With the default active edge (rising), a 0→1 change gives `ref_clr` = 1 for exactly one cycle. That cycle is the one after the second rising clock edge that sees the new level. A 1→0 change gives no pulse.
- R3: The carrier counter runs from 0 up to `carr_prd`. `carr_tick` is 1 for one cycle when the count reaches `carr_prd`, so ticks are `carr_prd`+1 cycles apart.
- R4: `sine_idx` increments by one on each clock edge where `carr_tick` is 1, wraps from N−1 to 0, and holds otherwise.
- R5: The midpoint event happens when `sine_idx` becomes N/2. `ref_cnt` is sampled at the next clock edge. `carr_prd` takes its new value at the fourth clock edge after `sine_idx` became N/2, and keeps its old value until then.
- R6: The error is the sampled count minus floor(`ref_prd`/2). The correction is (error >>> KP_SHIFT) + (integrator >>> KI_SHIFT), using arithmetic shifts. The unclamped period is `carr_nom` − correction.
- R7: At each midpoint the integrator adds the error and saturates to the range −INT_LIM to +INT_LIM.
- R8: `carr_prd` is limited to the range [`carr_min`, `carr_max`].
- R9: During reset, `sine_idx`, `carr_tick`, `ref_clr` and `sync_out` are 0. The integrator and correction are also 0, so `carr_prd` equals `carr_nom` clamped to the limits.
- R10: The regulator steps PI_IDLE→PI_ERROR→PI_INTEG→PI_APPLY→PI_IDLE, one state per clock. It leaves PI_IDLE only on a midpoint event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_cnt | input | CW | Local reference counter value |
| ref_prd | input | CW | Reference counter period |
| sync_in | input | 1 | Combined shared sync line |
| carr_nom | input | PW | Nominal carrier period |
| carr_min | input | PW | Lower carrier period limit |
| carr_max | input | PW | Upper carrier period limit |
| sync_out | output | 1 | Square wave driven onto the sync line |
| ref_clr | output | 1 | One-cycle request to clear the reference counter |
| carr_prd | output | PW | Regulated carrier period |
| carr_tick | output | 1 | One-cycle pulse at each carrier wrap |
| sine_idx | output | $clog2(N) | Sine sample index |

## Verification
The clamp assertion only holds when `carr_min` does not exceed `carr_max`, so it is guarded by that condition. The regulator assumes that `ref_cnt` and `ref_prd` stay steady from the midpoint until the state machine returns to idle. The synchronizer assertion assumes that `sync_in` is free of glitches at clock resolution. The stimulus follows all of these assumptions. It changes `ref_cnt` and `ref_prd` only long after a correction has settled, keeps the limits ordered, and changes `sync_in` only on falling clock edges, holding each level for several cycles.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

    typedef enum logic [1:0] {
        PI_IDLE  = 2'd0,
        PI_ERROR = 2'd1,
        PI_INTEG = 2'd2,
        PI_APPLY = 2'd3
    } pi_state_e;

endpackage

// File: rtl/sbl_sync_edge.sv
module sbl_sync_edge #(
    parameter int STAGES    = 2,
    parameter bit EDGE_RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_in,
    output logic clr_pulse
);

    localparam logic REST_LVL = EDGE_RISE ? 1'b0 : 1'b1;

    logic [STAGES-1:0] sync_q;
    logic              hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {STAGES{REST_LVL}};
            hist_q <= REST_LVL;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], bus_in};
            hist_q <= sync_q[STAGES-1];
        end
    end

    generate
        if (EDGE_RISE) begin : g_rise
            assign clr_pulse = sync_q[STAGES-1] & ~hist_q;
        end else begin : g_fall
            assign clr_pulse = ~sync_q[STAGES-1] & hist_q;
        end
    endgenerate

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> !clr_pulse);

    // R2
    pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |-> ($past(bus_in, STAGES) == ~REST_LVL));

endmodule

// File: rtl/sbl_carrier.sv
module sbl_carrier #(
    parameter int PW = 16,
    parameter int N  = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PW-1:0]        carr_prd,
    output logic                 tick,
    output logic [$clog2(N)-1:0] idx,
    output logic                 mid
);

    localparam int IDXW = $clog2(N);
    localparam int HALF = N / 2;

    logic [PW-1:0]   cnt_q;
    logic [IDXW-1:0] idx_q;
    logic            mid_q;
    logic            wrap;

    assign wrap = (cnt_q >= carr_prd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            mid_q <= 1'b0;
        end else begin
            mid_q <= wrap && (idx_q == IDXW'(HALF - 1));
            if (wrap) begin
                cnt_q <= '0;
                if (idx_q == IDXW'(N - 1)) begin
                    idx_q <= '0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign tick = wrap;
    assign idx  = idx_q;
    assign mid  = mid_q;

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

    // R4
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(idx_q));

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(idx_q) < N);

    // R5
    mid_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mid_q |-> (idx_q == IDXW'(HALF)));

endmodule

// File: rtl/sbl_pi.sv
module sbl_pi
    import sbl_pkg::*;
#(
    parameter int CW       = 16,
    parameter int PW       = 16,
    parameter int KP_SHIFT = 2,
    parameter int KI_SHIFT = 4,
    parameter int INT_LIM  = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mid,
    input  logic [CW-1:0] ref_cnt,
    input  logic [CW-1:0] ref_prd,
    input  logic [PW-1:0] carr_nom,
    input  logic [PW-1:0] carr_min,
    input  logic [PW-1:0] carr_max,
    output logic [PW-1:0] carr_prd
);

    localparam int IW = CW + 3;
    localparam int SW = IW + 1;
    localparam int RW = (SW > PW ? SW : PW) + 2;
    localparam logic signed [IW:0] LIM_HI = (IW+1)'(INT_LIM);
    localparam logic signed [IW:0] LIM_LO = -LIM_HI;

    pi_state_e state_q, state_d;

    logic        [CW-1:0] fb_q;
    logic signed [CW:0]   err_q;
    logic signed [IW-1:0] integ_q;
    logic signed [SW-1:0] corr_q;
    logic signed [IW:0]   acc_sum;
    logic signed [IW-1:0] acc_sat;
    logic signed [RW-1:0] nom_s, min_s, max_s, raw;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PI_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PI_IDLE:  if (mid) state_d = PI_ERROR;
            PI_ERROR: state_d = PI_INTEG;
            PI_INTEG: state_d = PI_APPLY;
            PI_APPLY: state_d = PI_IDLE;
            default:  state_d = PI_IDLE;
        endcase
    end

    // saturating accumulation
    always_comb begin
        acc_sum = (IW+1)'(integ_q) + (IW+1)'(err_q);
        if (acc_sum > LIM_HI) begin
            acc_sat = IW'(LIM_HI);
        end else if (acc_sum < LIM_LO) begin
            acc_sat = IW'(LIM_LO);
        end else begin
            acc_sat = $signed(acc_sum[IW-1:0]);
        end
    end

    // datapath outputs per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fb_q    <= '0;
            err_q   <= '0;
            integ_q <= '0;
            corr_q  <= '0;
        end else begin
            unique case (state_q)
                PI_IDLE:  if (mid) fb_q <= ref_cnt;
                PI_ERROR: err_q <= $signed({1'b0, fb_q}) - $signed({1'b0, ref_prd >> 1});
                PI_INTEG: integ_q <= acc_sat;
                PI_APPLY: corr_q <= SW'(err_q >>> KP_SHIFT) + SW'(integ_q >>> KI_SHIFT);
                default:  ;
            endcase
        end
    end

    // period clamp
    always_comb begin
        nom_s = $signed({{(RW-PW){1'b0}}, carr_nom});
        min_s = $signed({{(RW-PW){1'b0}}, carr_min});
        max_s = $signed({{(RW-PW){1'b0}}, carr_max});
        raw   = nom_s - RW'(corr_q);
        if (raw < min_s) begin
            carr_prd = carr_min;
        end else if (raw > max_s) begin
            carr_prd = carr_max;
        end else begin
            carr_prd = raw[PW-1:0];
        end
    end

    // R10
    idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PI_IDLE && !mid) |=> (state_q == PI_IDLE));

    // R10
    err_to_integ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PI_ERROR) |=> (state_q == PI_INTEG));

    // R10
    apply_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PI_APPLY) |=> (state_q == PI_IDLE));

    // R7
    integ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((IW+1)'(integ_q) <= LIM_HI) && ((IW+1)'(integ_q) >= LIM_LO));

    // R5
    corr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PI_APPLY) |=> $stable(corr_q));

    // R8
    prd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carr_min <= carr_max) |-> (carr_prd >= carr_min && carr_prd <= carr_max));

endmodule

// File: rtl/sbl_top.sv
module sbl_top #(
    parameter int CW          = 16,
    parameter int PW          = 16,
    parameter int N           = 256,
    parameter int KP_SHIFT    = 2,
    parameter int KI_SHIFT    = 4,
    parameter int INT_LIM     = 4096,
    parameter int SYNC_STAGES = 2,
    parameter bit EDGE_RISE   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CW-1:0]        ref_cnt,
    input  logic [CW-1:0]        ref_prd,
    input  logic                 sync_in,
    input  logic [PW-1:0]        carr_nom,
    input  logic [PW-1:0]        carr_min,
    input  logic [PW-1:0]        carr_max,
    output logic                 sync_out,
    output logic                 ref_clr,
    output logic [PW-1:0]        carr_prd,
    output logic                 carr_tick,
    output logic [$clog2(N)-1:0] sine_idx
);

    logic sync_out_q;
    logic mid_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_out_q <= 1'b0;
        end else begin
            sync_out_q <= (ref_cnt < (ref_prd >> 1));
        end
    end

    assign sync_out = sync_out_q;

    sbl_sync_edge #(
        .STAGES    (SYNC_STAGES),
        .EDGE_RISE (EDGE_RISE)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_in    (sync_in),
        .clr_pulse (ref_clr)
    );

    sbl_carrier #(
        .PW (PW),
        .N  (N)
    ) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .carr_prd (carr_prd),
        .tick     (carr_tick),
        .idx      (sine_idx),
        .mid      (mid_evt)
    );

    sbl_pi #(
        .CW       (CW),
        .PW       (PW),
        .KP_SHIFT (KP_SHIFT),
        .KI_SHIFT (KI_SHIFT),
        .INT_LIM  (INT_LIM)
    ) u_pi (
        .clk      (clk),
        .rst_n    (rst_n),
        .mid      (mid_evt),
        .ref_cnt  (ref_cnt),
        .ref_prd  (ref_prd),
        .carr_nom (carr_nom),
        .carr_min (carr_min),
        .carr_max (carr_max),
        .carr_prd (carr_prd)
    );

    // R1
    sync_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> ($past(ref_cnt) < ($past(ref_prd) >> 1)));

    // R1
    sync_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_out |-> ($past(ref_cnt) >= ($past(ref_prd) >> 1)));

endmodule

// File: tb/sbl_top_tb_top.sv
module sbl_top_tb_top;

    localparam int CW   = 16;
    localparam int PW   = 16;
    localparam int N    = 16;
    localparam int HALF = N / 2;
    localparam int IDXW = $clog2(N);
    localparam int VEC_N = 11;

    // {ref_cnt held at midpoint, expected carr_prd afterwards}
    localparam int VEC [VEC_N][2] = '{
        '{50, 20}, '{58, 14}, '{58, 12}, '{70, 12}, '{30, 26}, '{20, 28},
        '{20, 28}, '{20, 28}, '{50, 28}, '{60, 23}, '{60, 20}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CW-1:0]   ref_cnt = 16'd50;
    logic [CW-1:0]   ref_prd = 16'd100;
    logic            sync_in = 1'b0;
    logic [PW-1:0]   carr_nom = 16'd20;
    logic [PW-1:0]   carr_min = 16'd12;
    logic [PW-1:0]   carr_max = 16'd28;
    logic            sync_out, ref_clr, carr_tick;
    logic [PW-1:0]   carr_prd;
    logic [IDXW-1:0] sine_idx;

    int checks = 0;
    int errs   = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    sbl_top #(
        .CW (CW), .PW (PW), .N (N), .KP_SHIFT (1), .KI_SHIFT (2),
        .INT_LIM (40), .SYNC_STAGES (2), .EDGE_RISE (1'b1)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .ref_cnt (ref_cnt), .ref_prd (ref_prd),
        .sync_in (sync_in), .carr_nom (carr_nom), .carr_min (carr_min),
        .carr_max (carr_max), .sync_out (sync_out), .ref_clr (ref_clr),
        .carr_prd (carr_prd), .carr_tick (carr_tick), .sine_idx (sine_idx)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int prev;
        int gap;
        int i0;
        // R9: reset state, clamp applied to nominal while in reset
        repeat (2) @(negedge clk);
        chk("R9 sine_idx", int'(sine_idx), 0);
        chk("R9 carr_tick", int'(carr_tick), 0);
        chk("R9 ref_clr", int'(ref_clr), 0);
        chk("R9 sync_out", int'(sync_out), 0);
        chk("R9 carr_prd nominal", int'(carr_prd), 20);
        carr_nom = 16'd5;
        @(negedge clk);
        chk("R8 low clamp in reset", int'(carr_prd), 12);
        carr_nom = 16'd40;
        @(negedge clk);
        chk("R8 high clamp in reset", int'(carr_prd), 28);
        carr_nom = 16'd20;
        @(negedge clk);
        rst_n = 1'b1;

        // R5 R6 R7 R8 table walk
        prev = 20;
        for (int v = 0; v < VEC_N; v++) begin
            ref_cnt = CW'(VEC[v][0]);
            while (int'(sine_idx) == HALF) @(negedge clk);
            while (int'(sine_idx) != HALF) @(negedge clk);
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk("R5 period held before update", int'(carr_prd), prev);
            @(posedge clk);
            @(negedge clk);
            chk("R6 R7 R8 regulated period", int'(carr_prd), VEC[v][1]);
            prev = VEC[v][1];
        end

        // fresh start for directed tests
        ref_cnt = 16'd50;
        do_reset();

        // R3 tick spacing and width
        while (!carr_tick) @(negedge clk);
        @(negedge clk);
        chk("R3 tick one cycle", int'(carr_tick), 0);
        gap = 1;
        while (!carr_tick) begin
            @(negedge clk);
            gap++;
        end
        chk("R3 tick spacing", gap, 21);

        // R4 index advance and wrap
        i0 = int'(sine_idx);
        @(negedge clk);
        chk("R4 advance on tick", int'(sine_idx), (i0 + 1) % N);
        while (int'(sine_idx) != N - 1) @(negedge clk);
        while (!carr_tick) @(negedge clk);
        @(negedge clk);
        chk("R4 wrap to zero", int'(sine_idx), 0);

        // R2 rising edge gives one pulse
        sync_in = 1'b1;
        @(negedge clk);
        chk("R2 no pulse after one edge", int'(ref_clr), 0);
        @(negedge clk);
        chk("R2 pulse after two edges", int'(ref_clr), 1);
        @(negedge clk);
        chk("R2 pulse one cycle", int'(ref_clr), 0);
        // R2 falling edge ignored
        sync_in = 1'b0;
        gap = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            gap += int'(ref_clr);
        end
        chk("R2 falling edge no pulse", gap, 0);

        // R1 sync square wave
        ref_cnt = 16'd49;
        @(negedge clk);
        chk("R1 below half", int'(sync_out), 1);
        ref_cnt = 16'd50;
        @(negedge clk);
        chk("R1 at half", int'(sync_out), 0);
        ref_cnt = 16'd0;
        @(negedge clk);
        chk("R1 zero count", int'(sync_out), 1);
        ref_prd = 16'd101;
        ref_cnt = 16'd50;
        @(negedge clk);
        chk("R1 odd period floor", int'(sync_out), 0);
        ref_prd = 16'd100;

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule